// File: doc/BRIEF.md
# Memory protection region checker

This block decides, in a single lookup, whether a memory access may proceed. It holds a small table of address regions. Each region has a base word and a permission word. A global control word turns checking on and off and supplies fallback permissions. Software programs all of these through a narrow register port that writes on a clock edge and reads back without delay.

For each access, the block is given the address, the privilege level (user or kernel) and the kind (read, write or execute). It compares the address against every valid region in parallel. The lowest-numbered region that contains the address supplies the permissions. If no region contains the address, the fallback permissions apply. One cycle after the request, the result appears on registered outputs: grant or violation, a hit flag, and the index of the deciding region.

The number of regions is a parameter, from 2 to 16. Register addresses set aside for regions beyond that number behave as empty locations.

Top module: `mpu_region_check`

## Requirements
- R1: Register map. Region i has its base word at 0x422+2*i and its permission word at 0x423+2*i. The control word is at 0x409. Reading returns the last value written, masked as follows: base word all 32 bits, permission word bits [11:0], control word bit 30 and bits [8:2]. All other bits, and any unmapped address, read as zero.
- R2: After reset, every register reads zero, checking is off, every region is invalid, and all result outputs are low.
- R3: While control bit 30 is clear, every access is granted.
- R4: Region coverage. A region takes part only when bit 0 of its base word is set. Its size field f is {perm[11:9], perm[1:0]}. The region covers addresses from {base[31:1],1'b0} up to, but not including, that value plus 2^(f+1).
- R5: A size field below 10 is treated as 10, so the smallest region is 2048 bytes.
- R6: When several valid regions contain the address, the one with the lowest index alone decides the result.
- R7: Permission bits sit in bits [7:2] of a permission word: kernel execute at bit 2, kernel write at 3, kernel read at 4, user execute at 5, user write at 6, user read at 7. The access kind is coded as 0 for read, 1 for write, and 2 or 3 for execute. acc_user=1 selects the user bits. The single bit selected by level and kind grants the access.
- R8: An access that misses every region is judged by the same bit layout, taken from control word bits [7:2]. On a miss, chk_hit is 0 and chk_region is 0. On a hit, chk_region is the deciding index.
- R9: The results are registered. chk_valid is high for exactly the cycle after acc_valid is sampled. The lookup uses the register contents from before a register write that lands on the same edge.
- R10: Register addresses of regions at or above the region count read as zero. Writes to them have no effect on any lookup.
- R11: While chk_valid is high, exactly one of chk_grant and chk_viol is high. While chk_valid is low, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access address |
| acc_user | input | 1 | 1 = user level, 0 = kernel level |
| acc_kind | input | 2 | 0 read, 1 write, 2/3 execute |
| chk_valid | output | 1 | Result present |
| chk_grant | output | 1 | Access permitted |
| chk_viol | output | 1 | Access refused |
| chk_hit | output | 1 | A region decided the result |
| chk_region | output | 4 | Index of the deciding region |

## Verification
A register write and an access lookup can fall on the same clock edge. The bench provokes this by invalidating the region that covers an address while, in the same cycle, it requests an access to that address. The result is judged correct when it still reports a hit on that region with a grant. A second access right afterwards must then report a miss.

// File: rtl/mpu_region_check.sv
module mpu_region_check #(
  parameter int NUM_REGIONS = 8,
  parameter int IW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic        acc_user,
  input  logic [1:0]  acc_kind,
  output logic        chk_valid,
  output logic        chk_grant,
  output logic        chk_viol,
  output logic        chk_hit,
  output logic [IW-1:0] chk_region
);

  localparam logic [11:0] REG_BASE0 = 12'h422;
  localparam logic [11:0] REG_CTRL  = 12'h409;
  localparam logic [11:0] REG_SPAN  = 12'(2 * NUM_REGIONS);

  logic [31:0] base_q [NUM_REGIONS];
  logic [11:0] perm_q [NUM_REGIONS];
  logic        mpu_on;
  logic [6:0]  dflt_q;

  wire [11:0]   roff   = reg_addr - REG_BASE0;
  wire          in_win = (reg_addr >= REG_BASE0) && (roff < REG_SPAN);
  wire [IW-1:0] ridx   = roff[IW:1];

  function automatic logic covers(input logic [31:0] b, input logic [11:0] p,
                                  input logic [31:0] a);
    logic [4:0]  f;
    logic [5:0]  sz;
    logic [32:0] lo, hi;
    f  = {p[11:9], p[1:0]};
    sz = (f < 5'd10) ? 6'd11 : {1'b0, f} + 6'd1;
    lo = {1'b0, b[31:1], 1'b0};
    hi = lo + (33'd1 << sz);
    return b[0] && ({1'b0, a} >= lo) && ({1'b0, a} < hi);
  endfunction

  function automatic logic allowed(input logic [6:0] attr, input logic user,
                                   input logic [1:0] kind);
    logic [2:0] sel;
    sel = user ? 3'd3 : 3'd0;
    case (kind)
      2'd0:    sel = sel + 3'd2;
      2'd1:    sel = sel + 3'd1;
      default: sel = sel;
    endcase
    return attr[sel];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        base_q[i] <= '0;
        perm_q[i] <= '0;
      end
      mpu_on <= 1'b0;
      dflt_q <= '0;
    end else if (reg_we) begin
      if (in_win) begin
        if (roff[0]) perm_q[ridx] <= reg_wdata[11:0];
        else         base_q[ridx] <= reg_wdata;
      end else if (reg_addr == REG_CTRL) begin
        mpu_on <= reg_wdata[30];
        dflt_q <= reg_wdata[8:2];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_win)
      reg_rdata = roff[0] ? {20'd0, perm_q[ridx]} : base_q[ridx];
    else if (reg_addr == REG_CTRL)
      reg_rdata = {1'b0, mpu_on, 21'd0, dflt_q, 2'b00};
  end

  logic          hit_c;
  logic [IW-1:0] idx_c;
  logic [6:0]    attr_c;

  always_comb begin
    hit_c  = 1'b0;
    idx_c  = '0;
    attr_c = dflt_q;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (covers(base_q[i], perm_q[i], acc_addr)) begin
        hit_c  = 1'b1;
        idx_c  = IW'(i);
        attr_c = perm_q[i][8:2];
      end
    end
  end

  wire ok_c = !mpu_on || allowed(attr_c, acc_user, acc_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid  <= 1'b0;
      chk_grant  <= 1'b0;
      chk_viol   <= 1'b0;
      chk_hit    <= 1'b0;
      chk_region <= '0;
    end else begin
      chk_valid  <= acc_valid;
      chk_grant  <= acc_valid && ok_c;
      chk_viol   <= acc_valid && !ok_c;
      chk_hit    <= acc_valid && hit_c;
      chk_region <= acc_valid ? idx_c : '0;
    end
  end

endmodule

// File: rtl/mpu_region_check_chk.sv
module mpu_region_check_chk #(
  parameter int NUM_REGIONS = 8,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [11:0]   reg_addr,
  input logic [31:0]   reg_rdata,
  input logic          mpu_on,
  input logic          chk_valid,
  input logic          chk_grant,
  input logic          chk_viol,
  input logic          chk_hit,
  input logic [IW-1:0] chk_region
);

  localparam logic [11:0] FIRST_GAP = 12'(12'h422 + 2 * NUM_REGIONS);

  // R9
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> chk_valid);

  // R9
  no_result_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !chk_valid);

  // R11
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> (chk_grant ^ chk_viol));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> !(chk_grant || chk_viol || chk_hit));

  // R3
  off_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !mpu_on) |=> chk_grant);

  // R8
  miss_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_hit |-> (chk_region == '0));

  // R10
  gap_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr >= FIRST_GAP) && (reg_addr < 12'h442)) |-> (reg_rdata == 32'd0));

endmodule

bind mpu_region_check mpu_region_check_chk #(.NUM_REGIONS(NUM_REGIONS), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .mpu_on(mpu_on), .chk_valid(chk_valid),
  .chk_grant(chk_grant), .chk_viol(chk_viol), .chk_hit(chk_hit),
  .chk_region(chk_region)
);

// File: tb/mpu_region_check_tb_top.sv
`timescale 1ns/1ps
module mpu_region_check_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_user = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic        chk_valid, chk_grant, chk_viol, chk_hit;
  logic [3:0]  chk_region;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mpu_region_check #(.NUM_REGIONS(8), .IW(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_user(acc_user), .acc_kind(acc_kind),
    .chk_valid(chk_valid), .chk_grant(chk_grant), .chk_viol(chk_viol),
    .chk_hit(chk_hit), .chk_region(chk_region[2:0])
  );
  assign chk_region[3] = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic acc(input logic [31:0] a, input logic u, input logic [1:0] k);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_user = u; acc_kind = k;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic g, input logic h, input logic [3:0] r);
    check({tag, " valid"}, {31'd0, chk_valid}, 32'd1);
    check({tag, " grant"}, {31'd0, chk_grant}, {31'd0, g});
    check({tag, " viol"},  {31'd0, chk_viol},  {31'd0, !g});
    check({tag, " hit"},   {31'd0, chk_hit},   {31'd0, h});
    check({tag, " region"}, {28'd0, chk_region}, {28'd0, r});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h409, d); check("R2 ctrl", d, 0);
    rd(12'h422, d); check("R2 base0", d, 0);
    rd(12'h423, d); check("R2 perm0", d, 0);
    check("R2 valid", {31'd0, chk_valid}, 0);
    check("R2 grant", {31'd0, chk_grant}, 0);
  endtask

  task automatic t_disabled;
    acc(32'h1000_0000, 1'b1, 2'd1);
    expect_res("R3 off", 1'b1, 1'b0, 4'd0);
    @(negedge clk);
    check("R9 idle", {31'd0, chk_valid}, 0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(12'h429, 32'hFFFF_FFFF); rd(12'h429, d); check("R1 perm mask", d, 32'h0000_0FFF);
    wr(12'h428, 32'h1234_5678); rd(12'h428, d); check("R1 base", d, 32'h1234_5678);
    wr(12'h409, 32'hFFFF_FFFF); rd(12'h409, d); check("R1 ctrl mask", d, 32'h4000_01FC);
    wr(12'h409, 32'h0);         rd(12'h409, d); check("R1 ctrl clear", d, 0);
    wr(12'h429, 32'h0);
    rd(12'h400, d); check("R1 unmapped", d, 0);
  endtask

  task automatic t_basic;
    wr(12'h427, 32'h0000_0493);
    wr(12'h426, 32'h1000_0001);
    wr(12'h409, 32'h4000_0000);
    acc(32'h1000_0FFF, 1'b1, 2'd0); expect_res("R4 top byte", 1'b1, 1'b1, 4'd2);
    acc(32'h1000_0FFF, 1'b1, 2'd1); expect_res("R7 user write", 1'b0, 1'b1, 4'd2);
    acc(32'h1000_1000, 1'b1, 2'd0); expect_res("R4 end excl", 1'b0, 1'b0, 4'd0);
    acc(32'h0FFF_FFFF, 1'b0, 2'd0); expect_res("R4 below", 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_overlap;
    wr(12'h425, 32'h0000_044A);
    wr(12'h424, 32'h1000_0001);
    acc(32'h1000_0100, 1'b1, 2'd0); expect_res("R6 low wins", 1'b0, 1'b1, 4'd1);
    acc(32'h1000_0100, 1'b1, 2'd1); expect_res("R6 low grants", 1'b1, 1'b1, 4'd1);
    acc(32'h1000_0900, 1'b1, 2'd0); expect_res("R6 fallthrough", 1'b1, 1'b1, 4'd2);
  endtask

  task automatic t_min_size;
    wr(12'h423, 32'h0000_0020);
    wr(12'h422, 32'h2000_0001);
    acc(32'h2000_07FC, 1'b1, 2'd2); expect_res("R5 inside", 1'b1, 1'b1, 4'd0);
    acc(32'h2000_0800, 1'b1, 2'd2); expect_res("R5 past 2K", 1'b0, 1'b0, 4'd0);
    acc(32'h2000_0000, 1'b1, 2'd3); expect_res("R7 kind3 exec", 1'b1, 1'b1, 4'd0);
  endtask

  task automatic t_kernel;
    wr(12'h42B, 32'h0000_040A);
    wr(12'h42A, 32'h3000_0001);
    acc(32'h3000_0010, 1'b0, 2'd1); expect_res("R7 kernel write", 1'b1, 1'b1, 4'd4);
    acc(32'h3000_0010, 1'b1, 2'd1); expect_res("R7 user blocked", 1'b0, 1'b1, 4'd4);
    acc(32'h3000_0010, 1'b0, 2'd0); expect_res("R7 kernel read", 1'b0, 1'b1, 4'd4);
  endtask

  task automatic t_default;
    wr(12'h409, 32'h4000_0080);
    acc(32'h7000_0000, 1'b1, 2'd0); expect_res("R8 dflt user read", 1'b1, 1'b0, 4'd0);
    acc(32'h7000_0000, 1'b1, 2'd1); expect_res("R8 dflt user write", 1'b0, 1'b0, 4'd0);
    acc(32'h7000_0000, 1'b0, 2'd0); expect_res("R8 dflt kernel read", 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_unimpl;
    logic [31:0] d;
    wr(12'h433, 32'h0000_04FF);
    wr(12'h432, 32'h5000_0001);
    rd(12'h432, d); check("R10 base read", d, 0);
    rd(12'h433, d); check("R10 perm read", d, 0);
    acc(32'h5000_0000, 1'b0, 2'd1); expect_res("R10 no region", 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'h422; reg_wdata = 32'h0;
    acc_valid = 1'b1; acc_addr = 32'h2000_0000; acc_user = 1'b1; acc_kind = 2'd2;
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0;
    expect_res("R9 old state", 1'b1, 1'b1, 4'd0);
    acc(32'h2000_0000, 1'b1, 2'd2); expect_res("R9 new state", 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_disable;
    wr(12'h409, 32'h0000_0000);
    acc(32'h1000_0F00, 1'b1, 2'd1);
    check("R3 off grant", {31'd0, chk_grant}, 1);
    check("R3 off viol", {31'd0, chk_viol}, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_disabled;
    t_readback;
    t_basic;
    t_overlap;
    t_min_size;
    t_kernel;
    t_default;
    t_unimpl;
    t_same_cycle;
    t_disable;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule